// File: doc/BRIEF.md
# Sleep Mode Clock Gating Controller

This block decides which clock domains of a small controller keep running. While the device is awake, the CPU clock and the main oscillator run. Each I/O peripheral clock and the ADC clock can be turned off one at a time by its own power-reduction bit. The slow timer oscillator runs whenever the asynchronous timer asks for it.

When the CPU issues a sleep strobe while the sleep-enable bit is set, the block latches the selected sleep mode and drops the domains that mode does not need. There are four modes, from shallowest to deepest:
- **Idle** stops only the CPU.
- **ADC noise-reduction** also stops the I/O clocks but keeps the ADC and the main oscillator alive.
- **Power-save** keeps only the slow oscillator.
- **Power-down** stops everything, including the slow oscillator.

A wake event that the current mode accepts returns the block to the awake state. The state machine runs on the rising edge of the main clock. Every gate enable is re-registered on the falling edge, so an enable only changes while the clocks it gates are low.

Top module: `slpgate_ctrl`

## Requirements
- R1: A sleep strobe sampled on a rising edge puts the block to sleep only if `sleep_en_i` is high in that cycle; with `sleep_en_i` low the strobe has no effect and every enable keeps its awake value.
- R2: Idle mode is selected by `mode_sel_i` = 0 and by every unused code (4 to 7). In idle, `cpu_ce_o` is 0, `io_ce_o[i]` = NOT `prr_i[i]`, `adc_ce_o` = NOT `adc_pr_i`, `main_osc_en_o` is 1 and `slow_osc_en_o` = `slow_req_i`.
- R3: ADC noise-reduction mode (`mode_sel_i` = 1) has CPU and all I/O enables at 0, `adc_ce_o` = NOT `adc_pr_i`, `main_osc_en_o` at 1 and `slow_osc_en_o` = `slow_req_i`.
- R4: Power-save mode (`mode_sel_i` = 3) has every enable at 0 except `slow_osc_en_o`, which equals `slow_req_i`.
- R5: Power-down mode (`mode_sel_i` = 2) has every enable at 0, including `slow_osc_en_o`.
- R6: While awake, `cpu_ce_o` and `main_osc_en_o` are 1, `io_ce_o[i]` = NOT `prr_i[i]`, `adc_ce_o` = NOT `adc_pr_i` and `slow_osc_en_o` = `slow_req_i`.
- R7: Which wake inputs a mode accepts:
  - `wake_ext_i` wakes every mode.
  - `wake_tmr_i` wakes idle and power-save only.
  - `wake_adc_i` wakes idle and ADC noise-reduction only.
  - Any other wake input leaves the block asleep.
- R8: When an accepted wake is sampled on a rising edge, `cpu_ce_o` returns to 1 at the next falling edge, and `awake_o` always equals `cpu_ce_o`.
- R9: All outputs change only at a falling clock edge; they hold still across each rising edge and the high phase.
- R10: While asleep, further sleep strobes and changes of `mode_sel_i` are ignored; the mode latched on entry stays in force.
- R11: For the same inputs, the number of enabled outputs in power-down ≤ power-save ≤ ADC noise-reduction ≤ idle.
- R12: During reset, `cpu_ce_o`, all `io_ce_o`, `adc_ce_o`, `main_osc_en_o` and `awake_o` are 1 and `slow_osc_en_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Free-running main clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slow_req_i | input | 1 | Asynchronous timer asks for the slow oscillator |
| sleep_en_i | input | 1 | Sleep-enable bit |
| mode_sel_i | input | 3 | Sleep mode code (0 idle, 1 ADC noise-reduction, 2 power-down, 3 power-save, others idle) |
| sleep_strobe_i | input | 1 | One-cycle sleep instruction strobe |
| prr_i | input | NPERIPH | Per-peripheral clock disable bits |
| adc_pr_i | input | 1 | ADC clock disable bit |
| wake_ext_i | input | 1 | External interrupt wake event |
| wake_tmr_i | input | 1 | Asynchronous timer match wake event |
| wake_adc_i | input | 1 | ADC conversion complete wake event |
| cpu_ce_o | output | 1 | CPU clock gate enable |
| io_ce_o | output | NPERIPH | Per-peripheral I/O clock gate enables |
| adc_ce_o | output | 1 | ADC clock gate enable |
| main_osc_en_o | output | 1 | Main oscillator enable |
| slow_osc_en_o | output | 1 | Slow timer oscillator enable |
| awake_o | output | 1 | High while the CPU clock is enabled |

## Verification
Random stimulus mixes three things:
- strobes with and without the enable bit, which separates entry from ignored strobes;
- all eight mode codes, which separates the four gating maps and the aliasing of unused codes onto idle;
- each wake source against each mode, which separates accepted wakes from ignored ones.

Random power-reduction and slow-request patterns show whether each output follows its own mask or is forced off by the mode. Directed runs then cover:
- strobes and mode changes made while asleep;
- a wake that arrives together with a strobe;
- the ordering of enable counts across the four modes under identical inputs.

// File: rtl/slpgate_pkg.sv
package slpgate_pkg;

  localparam int unsigned MODE_SEL_W = 3;

  typedef enum logic [1:0] {
    SM_IDLE  = 2'd0,
    SM_ADCNR = 2'd1,
    SM_PSAVE = 2'd2,
    SM_PDOWN = 2'd3
  } slp_mode_e;

  // Domains a state permits; the per-peripheral masks are applied afterwards.
  typedef struct packed {
    logic cpu;
    logic io;
    logic adc;
    logic main_osc;
    logic slow_osc;
  } keep_t;

  function automatic slp_mode_e decode_mode(input logic [MODE_SEL_W-1:0] sel);
    slp_mode_e m;
    case (sel)
      3'd1:    m = SM_ADCNR;
      3'd2:    m = SM_PDOWN;
      3'd3:    m = SM_PSAVE;
      default: m = SM_IDLE;
    endcase
    return m;
  endfunction

  function automatic logic wake_ok(input slp_mode_e m, input logic ext,
                                   input logic tmr, input logic adc);
    logic tmr_ok;
    logic adc_ok;
    tmr_ok = (m == SM_IDLE) || (m == SM_PSAVE);
    adc_ok = (m == SM_IDLE) || (m == SM_ADCNR);
    return ext | (tmr & tmr_ok) | (adc & adc_ok);
  endfunction

  function automatic keep_t domain_keep(input logic asleep, input slp_mode_e m);
    keep_t k;
    k = '1;
    if (asleep) begin
      case (m)
        SM_IDLE:  k.cpu = 1'b0;
        SM_ADCNR: begin
          k.cpu = 1'b0;
          k.io  = 1'b0;
        end
        SM_PSAVE: begin
          k          = '0;
          k.slow_osc = 1'b1;
        end
        default:  k = '0;
      endcase
    end
    return k;
  endfunction

endpackage

// File: rtl/slpgate_seq.sv
module slpgate_seq
  import slpgate_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  sleep_en_i,
  input  logic                  sleep_strobe_i,
  input  logic [MODE_SEL_W-1:0] mode_sel_i,
  input  logic                  wake_ext_i,
  input  logic                  wake_tmr_i,
  input  logic                  wake_adc_i,
  output logic                  asleep_o,
  output slp_mode_e             mode_o,
  output logic                  enter_o,
  output logic                  wake_o
);

  logic      asleep_q;
  slp_mode_e mode_q;

  assign enter_o = !asleep_q && sleep_strobe_i && sleep_en_i;
  assign wake_o  = asleep_q && wake_ok(mode_q, wake_ext_i, wake_tmr_i, wake_adc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      asleep_q <= 1'b0;
      mode_q   <= SM_IDLE;
    end else if (enter_o) begin
      asleep_q <= 1'b1;
      mode_q   <= decode_mode(mode_sel_i);
    end else if (wake_o) begin
      asleep_q <= 1'b0;
    end
  end

  assign asleep_o = asleep_q;
  assign mode_o   = mode_q;

endmodule

// File: rtl/slpgate_map.sv
module slpgate_map
  import slpgate_pkg::*;
#(
  parameter int unsigned NPERIPH = 5
) (
  input  logic               asleep_i,
  input  slp_mode_e          mode_i,
  input  logic [NPERIPH-1:0] prr_i,
  input  logic               adc_pr_i,
  input  logic               slow_req_i,
  output logic               cpu_d_o,
  output logic [NPERIPH-1:0] io_d_o,
  output logic               adc_d_o,
  output logic               main_d_o,
  output logic               slow_d_o,
  output logic               awake_d_o
);

  keep_t keep;

  assign keep      = domain_keep(asleep_i, mode_i);
  assign cpu_d_o   = keep.cpu;
  assign adc_d_o   = keep.adc & ~adc_pr_i;
  assign main_d_o  = keep.main_osc;
  assign slow_d_o  = keep.slow_osc & slow_req_i;
  assign awake_d_o = ~asleep_i;

  for (genvar g = 0; g < NPERIPH; g++) begin : g_io
    assign io_d_o[g] = keep.io & ~prr_i[g];
  end

endmodule

// File: rtl/slpgate_out.sv
module slpgate_out #(
  parameter int unsigned     W       = 8,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  // Falling-edge update: gated clocks are low when an enable moves.
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= RST_VAL;
    else         q_o <= d_i;
  end

endmodule

// File: rtl/slpgate_ctrl.sv
module slpgate_ctrl
  import slpgate_pkg::*;
#(
  parameter int unsigned NPERIPH = 5
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  slow_req_i,
  input  logic                  sleep_en_i,
  input  logic [MODE_SEL_W-1:0] mode_sel_i,
  input  logic                  sleep_strobe_i,
  input  logic [NPERIPH-1:0]    prr_i,
  input  logic                  adc_pr_i,
  input  logic                  wake_ext_i,
  input  logic                  wake_tmr_i,
  input  logic                  wake_adc_i,
  output logic                  cpu_ce_o,
  output logic [NPERIPH-1:0]    io_ce_o,
  output logic                  adc_ce_o,
  output logic                  main_osc_en_o,
  output logic                  slow_osc_en_o,
  output logic                  awake_o
);

  localparam int unsigned GATE_W = NPERIPH + 5;
  localparam logic [GATE_W-1:0] GATE_RST =
    {1'b1, {NPERIPH{1'b1}}, 1'b1, 1'b1, 1'b0, 1'b1};

  logic               asleep_w;
  slp_mode_e          mode_w;
  logic               enter_w;
  logic               wake_w;
  logic               cpu_d, adc_d, main_d, slow_d, awake_d;
  logic [NPERIPH-1:0] io_d;
  logic [GATE_W-1:0]  gate_d, gate_q;

  slpgate_seq u_seq (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .sleep_en_i     (sleep_en_i),
    .sleep_strobe_i (sleep_strobe_i),
    .mode_sel_i     (mode_sel_i),
    .wake_ext_i     (wake_ext_i),
    .wake_tmr_i     (wake_tmr_i),
    .wake_adc_i     (wake_adc_i),
    .asleep_o       (asleep_w),
    .mode_o         (mode_w),
    .enter_o        (enter_w),
    .wake_o         (wake_w)
  );

  slpgate_map #(.NPERIPH(NPERIPH)) u_map (
    .asleep_i   (asleep_w),
    .mode_i     (mode_w),
    .prr_i      (prr_i),
    .adc_pr_i   (adc_pr_i),
    .slow_req_i (slow_req_i),
    .cpu_d_o    (cpu_d),
    .io_d_o     (io_d),
    .adc_d_o    (adc_d),
    .main_d_o   (main_d),
    .slow_d_o   (slow_d),
    .awake_d_o  (awake_d)
  );

  assign gate_d = {cpu_d, io_d, adc_d, main_d, slow_d, awake_d};

  slpgate_out #(.W(GATE_W), .RST_VAL(GATE_RST)) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (gate_d),
    .q_o    (gate_q)
  );

  assign {cpu_ce_o, io_ce_o, adc_ce_o, main_osc_en_o, slow_osc_en_o, awake_o} = gate_q;

endmodule

// File: rtl/slpgate_chk.sv
module slpgate_chk
  import slpgate_pkg::*;
#(
  parameter int unsigned NPERIPH = 5
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               sleep_en_i,
  input logic               sleep_strobe_i,
  input logic               wake_ext_i,
  input logic               asleep,
  input slp_mode_e          mode,
  input logic               cpu_ce_o,
  input logic [NPERIPH-1:0] io_ce_o,
  input logic               adc_ce_o,
  input logic               main_osc_en_o,
  input logic               slow_osc_en_o,
  input logic               awake_o
);

  localparam int unsigned OW = NPERIPH + 5;

  logic [OW-1:0] outs;
  logic [OW-1:0] snap;
  logic          seen;

  assign outs = {cpu_ce_o, io_ce_o, adc_ce_o, main_osc_en_o, slow_osc_en_o, awake_o};

  AST_NO_ENTRY_WITHOUT_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!asleep && sleep_strobe_i && !sleep_en_i) |=> !asleep) else $error("entry without enable"); // R1
  AST_ENTRY_WITH_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!asleep && sleep_strobe_i && sleep_en_i) |=> asleep) else $error("no entry"); // R1
  AST_ADCNR_GATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (asleep && mode == SM_ADCNR) |-> (!cpu_ce_o && io_ce_o == '0 && main_osc_en_o)) else $error("adcnr"); // R3
  AST_PSAVE_GATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (asleep && mode == SM_PSAVE) |-> (!cpu_ce_o && io_ce_o == '0 && !adc_ce_o && !main_osc_en_o)) else $error("psave"); // R4
  AST_PDOWN_DARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (asleep && mode == SM_PDOWN) |-> (outs == '0)) else $error("pdown"); // R5
  AST_EXT_WAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (asleep && wake_ext_i) |=> !asleep) else $error("ext wake"); // R7
  AST_AWAKE_IS_CPU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    awake_o == cpu_ce_o) else $error("awake vs cpu"); // R8
  AST_AWAKE_TRACKS_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    awake_o == !asleep) else $error("awake vs state"); // R8

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen <= 1'b0;
    else         seen <= 1'b1;
  end

  always_ff @(posedge clk_i) snap <= outs;

  always @(negedge clk_i) begin
    if (rst_ni && seen) begin
      AST_GATE_LOW_PHASE: assert (outs == snap) else $error("gate moved in high phase"); // R9
    end
  end

endmodule

bind slpgate_ctrl slpgate_chk #(.NPERIPH(NPERIPH)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .sleep_en_i     (sleep_en_i),
  .sleep_strobe_i (sleep_strobe_i),
  .wake_ext_i     (wake_ext_i),
  .asleep         (asleep_w),
  .mode           (mode_w),
  .cpu_ce_o       (cpu_ce_o),
  .io_ce_o        (io_ce_o),
  .adc_ce_o       (adc_ce_o),
  .main_osc_en_o  (main_osc_en_o),
  .slow_osc_en_o  (slow_osc_en_o),
  .awake_o        (awake_o)
);

// File: tb/slpgate_ctrl_tb.sv
`timescale 1ns/1ps
module slpgate_ctrl_tb_top;

  localparam int NP = 5;
  localparam int W  = NP + 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          slow_req, sleep_en, strobe, adc_pr, w_ext, w_tmr, w_adc;
  logic [2:0]    mode_sel;
  logic [NP-1:0] prr;
  logic          cpu_ce, adc_ce, main_en, slow_en, awake;
  logic [NP-1:0] io_ce;
  logic [W-1:0]  outs;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // Bench model of the sleep state: 0 idle, 1 adc-nr, 2 power-save, 3 power-down
  logic m_asleep = 1'b0;
  int   m_mode   = 0;

  always #2 clk = ~clk;   // 250 MHz

  slpgate_ctrl #(.NPERIPH(NP)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .slow_req_i(slow_req), .sleep_en_i(sleep_en),
    .mode_sel_i(mode_sel), .sleep_strobe_i(strobe), .prr_i(prr), .adc_pr_i(adc_pr),
    .wake_ext_i(w_ext), .wake_tmr_i(w_tmr), .wake_adc_i(w_adc),
    .cpu_ce_o(cpu_ce), .io_ce_o(io_ce), .adc_ce_o(adc_ce), .main_osc_en_o(main_en),
    .slow_osc_en_o(slow_en), .awake_o(awake)
  );

  assign outs = {cpu_ce, io_ce, adc_ce, main_en, slow_en, awake};

  function automatic int sel_to_mode(input logic [2:0] s);
    if (s == 3'd1) return 1;
    if (s == 3'd3) return 2;
    if (s == 3'd2) return 3;
    return 0;
  endfunction

  function automatic logic [W-1:0] model_outs(input logic slp, input int m,
      input logic [NP-1:0] pr, input logic apr, input logic sr);
    logic c, a, mo, so;
    logic [NP-1:0] io;
    c = 1'b0; a = 1'b0; mo = 1'b0; so = 1'b0; io = '0;
    if (!slp) begin
      c = 1'b1; io = ~pr; a = ~apr; mo = 1'b1; so = sr;
    end else if (m == 0) begin
      io = ~pr; a = ~apr; mo = 1'b1; so = sr;
    end else if (m == 1) begin
      a = ~apr; mo = 1'b1; so = sr;
    end else if (m == 2) begin
      so = sr;
    end
    return {c, io, a, mo, so, ~slp};
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // Enters at negedge+1; drives, crosses one rising and one falling edge, checks.
  task automatic cycle(input logic st, input logic en, input logic [2:0] sel,
      input logic we, input logic wt, input logic wa, input logic [NP-1:0] pr,
      input logic apr, input logic sr);
    logic [W-1:0] pre, exp;
    logic was_asleep, hit;
    string tag;
    strobe = st; sleep_en = en; mode_sel = sel; w_ext = we; w_tmr = wt; w_adc = wa;
    prr = pr; adc_pr = apr; slow_req = sr;
    pre = outs;
    @(posedge clk);
    was_asleep = m_asleep;
    hit = we || (wt && (m_mode == 0 || m_mode == 2)) || (wa && (m_mode == 0 || m_mode == 1));
    if (m_asleep) begin
      if (hit) m_asleep = 1'b0;
    end else if (st && en) begin
      m_asleep = 1'b1;
      m_mode   = sel_to_mode(sel);
    end
    #1;
    chk(outs == pre, "R9 stable across rising edge", outs, pre);
    @(negedge clk);
    #1;
    exp = model_outs(m_asleep, m_mode, pr, apr, sr);
    if (was_asleep && !m_asleep)                 tag = "R8 wake";
    else if (was_asleep && (we || wt || wa))     tag = "R7 ignored wake";
    else if (was_asleep && st)                   tag = "R10 strobe while asleep";
    else if (m_asleep && m_mode == 0)            tag = (sel > 3'd3) ? "R2 unused code idle" : "R2 idle";
    else if (m_asleep && m_mode == 1)            tag = "R3 adc-nr";
    else if (m_asleep && m_mode == 2)            tag = "R4 power-save";
    else if (m_asleep)                           tag = "R5 power-down";
    else if (st && !en)                          tag = "R1 strobe without enable";
    else                                         tag = "R6 awake gating";
    chk(outs == exp, tag, outs, exp);
  endtask

  initial begin : wd
    #(4 * 200000);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : main
    int cnt [4];
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; slow_req = 1'b1; sleep_en = 0; strobe = 0; adc_pr = 1;
    w_ext = 0; w_tmr = 0; w_adc = 0; mode_sel = 0; prr = '1;
    repeat (3) @(negedge clk);
    #1;
    // R12 reset values
    chk(outs == {1'b1, {NP{1'b1}}, 1'b1, 1'b1, 1'b0, 1'b1}, "R12 reset",
        outs, {1'b1, {NP{1'b1}}, 1'b1, 1'b1, 1'b0, 1'b1});
    rst_n = 1'b1;

    // R6 awake masks
    cycle(0, 0, 0, 0, 0, 0, 5'b10110, 1'b0, 1'b1);
    // R1 strobe without enable
    cycle(1, 0, 3'd2, 0, 0, 0, 5'b00001, 1'b1, 1'b0);
    // R5 power-down, R7 timer/adc wakes ignored, then external wakes (R8)
    cycle(1, 1, 3'd2, 0, 0, 0, '0, 1'b0, 1'b1);
    cycle(0, 0, 3'd2, 0, 1, 1, '0, 1'b0, 1'b1);
    cycle(0, 0, 3'd2, 1, 0, 0, '0, 1'b0, 1'b1);
    chk(awake == cpu_ce && awake, "R8 awake equals cpu enable", {W{awake}}, {W{cpu_ce}});
    // R4 power-save; R10 strobe and new code while asleep; timer wakes
    cycle(1, 1, 3'd3, 0, 0, 0, 5'b01010, 1'b0, 1'b1);
    cycle(1, 1, 3'd2, 0, 0, 1, 5'b01010, 1'b0, 1'b1);
    cycle(0, 1, 3'd0, 0, 1, 0, 5'b01010, 1'b0, 1'b0);
    // R3 adc-nr woken by adc completion, timer ignored
    cycle(1, 1, 3'd1, 0, 0, 0, 5'b00100, 1'b1, 1'b1);
    cycle(0, 0, 3'd1, 0, 1, 0, 5'b00100, 1'b0, 1'b1);
    cycle(0, 0, 3'd1, 0, 0, 1, 5'b00100, 1'b0, 1'b1);
    // R2 unused codes alias to idle
    for (int c = 4; c < 8; c++) begin
      cycle(1, 1, 3'(c), 0, 0, 0, 5'b11000, 1'b0, 1'b1);
      cycle(0, 0, 3'(c), 0, 0, 1, 5'b11000, 1'b0, 1'b1);
    end

    // R11 ordering of enabled-output counts
    begin
      logic [2:0] codes [4];
      codes[0] = 3'd0; codes[1] = 3'd1; codes[2] = 3'd3; codes[3] = 3'd2;
      for (int k = 0; k < 4; k++) begin
        cycle(1, 1, codes[k], 0, 0, 0, '0, 1'b0, 1'b1);
        cnt[k] = $countones(outs);
        cycle(0, 0, codes[k], 1, 0, 0, '0, 1'b0, 1'b1);
      end
      chk(cnt[3] <= cnt[2] && cnt[2] <= cnt[1] && cnt[1] <= cnt[0], "R11 mode ordering",
          W'(cnt[3] * 256 + cnt[2] * 16 + cnt[1]), W'(cnt[0]));
    end

    // Constrained random mix
    for (int i = 0; i < 4000; i++) begin
      cycle(($urandom % 4) == 0, ($urandom % 2) == 0, 3'($urandom % 8),
            ($urandom % 16) == 0, ($urandom % 8) == 0, ($urandom % 8) == 0,
            NP'($urandom), ($urandom % 3) == 0, ($urandom % 2) == 0);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule